// File: doc/BRIEF.md
# Event Interrupt Enable and Status Controller

This block turns single-cycle event pulses from neighbouring logic (data available, status valid, locality change, command ready) into one interrupt line. Each event source has its own enable bit. An enabled event latches into a sticky status bit, and software clears that bit by writing a one to it. A separate global enable bit decides whether pending status reaches the interrupt pin. A vector register stores the interrupt line number that software assigns. A read-only capability word reports which sources exist and which signalling style the output uses.

The same register set appears in every locality page. The page is chosen by address bits [15:12], and pages 0 to LOC_N-1 are valid. The output style is fixed at build time by a parameter: active-high level, active-low level, rising-edge pulse or falling-edge pulse. Register reads are combinational from the address. Writes take effect at the next rising clock edge.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, enable, vector and status read as zero, and the interrupt output is inactive.
- R2: Register offsets within a page are: enable 0x08, vector 0x0C, status 0x10, capability 0x14. Every page whose number in addr[15:12] is below LOC_N maps to the same registers. Other pages and other offsets read as zero, and writes to them change nothing.
- R3: The writable enable bits are 31 (global enable), 7, 2, 1 and 0. All other enable bits read as zero.
- R4: The vector register stores write-data bits [7:0]. It reads back zero-extended to 32 bits.
- R5: Event inputs evt_in[0], [1], [2] and [3] map to status bits 0, 1, 2 and 7 respectively. A pulse sets its status bit at the next edge when the enable bit at the same position is 1, whatever the global enable is. With that enable bit at 0 the pulse is ignored.
- R6: A write of 1 to a status bit clears it. A write of 0 leaves it unchanged.
- R7: An event that arrives in the same cycle as a write clearing its bit leaves the bit set.
- R8: The capability register is read-only. Bits 0, 1, 2 and 7 are always 1, and bit 8 equals BURST_STATIC. Exactly one of bits 3 to 6 is set, by MODE: 3 is level high, 4 is level low, 5 is rising edge, 6 is falling edge.
- R9: In level-high mode the output is 1 exactly one cycle after the global enable is set while some status bit is 1. It is 0 one cycle after that condition goes false.
- R10: In rising-edge mode the output gives a one-cycle pulse each time the condition "global enable and some status bit set" goes from false to true. There is no further pulse while the condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address (page in [15:12]) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| evt_in | input | 4 | Event pulses: data available, status valid, locality change, command ready |
| irq_out | output | 1 | Interrupt output, style set by MODE |

## Verification
The assertions check on every cycle that enabled events latch, that a clearing write without a competing event empties the bit, that writes outside the map leave enable and vector unchanged, that the level output is gated by the global enable, and that edge pulses last only one cycle. Only the bench scenarios show the exact read-back values: reserved-bit masking, vector truncation, page aliasing, capability contents for two build modes, and the ordering where an event meets a clearing write in the same cycle.

// File: rtl/evt_irq_pkg.sv
// Shared constants and types for the event interrupt controller.
// Assumes a 32-bit register data path and 4 KiB locality pages.
package evt_irq_pkg;

    localparam int unsigned DATA_W  = 32;
    localparam int unsigned NUM_SRC = 4;
    localparam int unsigned GIE_BIT = 31;

    localparam logic [11:0] OFF_ENABLE = 12'h008;
    localparam logic [11:0] OFF_VECTOR = 12'h00C;
    localparam logic [11:0] OFF_STATUS = 12'h010;
    localparam logic [11:0] OFF_CAPS   = 12'h014;

    // Output signalling style; ordinal + 3 is the capability bit.
    typedef enum logic [1:0] {
        IRQ_LVL_HI   = 2'd0,
        IRQ_LVL_LO   = 2'd1,
        IRQ_EDGE_RISE = 2'd2,
        IRQ_EDGE_FALL = 2'd3
    } irq_mode_e;

    // Bit position of event source k in enable, status and capability.
    function automatic int unsigned src_pos(input int unsigned k);
        case (k)
            0:       return 0;
            1:       return 1;
            2:       return 2;
            default: return 7;
        endcase
    endfunction

    // Mask of all source bit positions.
    function automatic logic [DATA_W-1:0] src_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int unsigned k = 0; k < NUM_SRC; k++) m[src_pos(k)] = 1'b1;
        return m;
    endfunction

    // Capability word for a build.
    function automatic logic [DATA_W-1:0] caps_word(input irq_mode_e mode, input bit burst);
        logic [DATA_W-1:0] c;
        c = src_mask();
        c[8] = burst;
        c[3 + int'(mode)] = 1'b1;
        return c;
    endfunction

endpackage

// File: rtl/evt_irq_decode.sv
// Address decoder: selects one register from a page-relative offset.
// Assumes ADDR_W > 12; pages at or above LOC_N select nothing.
module evt_irq_decode
    import evt_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned LOC_N  = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              sel_en,
    output logic              sel_vec,
    output logic              sel_st,
    output logic              sel_cap
);
    localparam int unsigned PG_W = ADDR_W - 12;

    logic [PG_W-1:0] page;
    logic [11:0]     off;
    logic            page_ok;

    assign page = addr[ADDR_W-1:12];
    assign off  = addr[11:0];

    // Page range check, then offset match.
    always_comb begin
        page_ok = (page < PG_W'(LOC_N));
        sel_en  = page_ok && (off == OFF_ENABLE);
        sel_vec = page_ok && (off == OFF_VECTOR);
        sel_st  = page_ok && (off == OFF_STATUS);
        sel_cap = page_ok && (off == OFF_CAPS);
    end
endmodule

// File: rtl/evt_irq_status.sv
// Sticky status bits, one per event source, cleared by a one-written.
// Assumes events are single-cycle pulses; a set always beats a clear.
module evt_irq_status
    import evt_irq_pkg::*;
#(
    parameter int unsigned N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] src_en,
    input  logic [N-1:0] clr,
    output logic [N-1:0] status
);
    for (genvar k = 0; k < N; k++) begin : g_bit
        // Latch an enabled event; otherwise honour a clear request.
        always_ff @(posedge clk) begin
            if (!rst_n)                   status[k] <= 1'b0;
            else if (evt[k] && src_en[k]) status[k] <= 1'b1;
            else if (clr[k])              status[k] <= 1'b0;
        end
    end
endmodule

// File: rtl/evt_irq_out.sv
// Output stage: turns the pending condition into the chosen signalling style.
// Level modes are one cycle behind pending; edge modes pulse on a 0->1 change.
module evt_irq_out
    import evt_irq_pkg::*;
#(
    parameter irq_mode_e MODE = IRQ_LVL_HI
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    output logic irq
);
    logic pend_q;
    logic rise;

    // Remember last cycle's pending condition.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pending;
    end

    assign rise = pending & ~pend_q;

    if (MODE == IRQ_LVL_HI) begin : g_lh
        assign irq = pend_q;
    end else if (MODE == IRQ_LVL_LO) begin : g_ll
        assign irq = ~pend_q;
    end else if (MODE == IRQ_EDGE_RISE) begin : g_er
        assign irq = rise;
    end else begin : g_ef
        assign irq = ~rise;
    end
endmodule

// File: rtl/evt_irq_ctrl.sv
// Top: enable, vector, status and capability registers with one interrupt out.
// Assumes a single-cycle write strobe and combinational read by address.
module evt_irq_ctrl
    import evt_irq_pkg::*;
#(
    parameter int unsigned ADDR_W       = 16,
    parameter int unsigned LOC_N        = 5,
    parameter int unsigned VEC_W        = 8,
    parameter bit          BURST_STATIC = 1'b0,
    parameter irq_mode_e   MODE         = IRQ_LVL_HI
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NUM_SRC-1:0] evt_in,
    output logic              irq_out
);
    localparam logic [DATA_W-1:0] SRC_MASK = src_mask();
    localparam logic [DATA_W-1:0] EN_MASK  = SRC_MASK | (DATA_W'(1) << GIE_BIT);
    localparam logic [DATA_W-1:0] CAPS     = caps_word(MODE, BURST_STATIC);

    logic sel_en, sel_vec, sel_st, sel_cap;
    logic [DATA_W-1:0]  en_q;
    logic [VEC_W-1:0]   vec_q;
    logic [NUM_SRC-1:0] src_en, clr, st_bits;
    logic [DATA_W-1:0]  status_w;
    logic               pending;

    evt_irq_decode #(.ADDR_W(ADDR_W), .LOC_N(LOC_N)) dec_i (
        .addr(reg_addr), .sel_en(sel_en), .sel_vec(sel_vec),
        .sel_st(sel_st), .sel_cap(sel_cap)
    );

    // Enable register: only global and source bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)              en_q <= '0;
        else if (reg_wr && sel_en) en_q <= reg_wdata & EN_MASK;
    end

    // Vector register: low VEC_W bits of write data.
    always_ff @(posedge clk) begin
        if (!rst_n)               vec_q <= '0;
        else if (reg_wr && sel_vec) vec_q <= reg_wdata[VEC_W-1:0];
    end

    // Gather per-source enable and clear bits from their register positions.
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        assign src_en[k] = en_q[src_pos(k)];
        assign clr[k]    = reg_wr && sel_st && reg_wdata[src_pos(k)];
    end

    evt_irq_status #(.N(NUM_SRC)) st_i (
        .clk(clk), .rst_n(rst_n), .evt(evt_in), .src_en(src_en),
        .clr(clr), .status(st_bits)
    );

    // Spread source status bits back to their register positions.
    always_comb begin
        status_w = '0;
        for (int unsigned k = 0; k < NUM_SRC; k++) status_w[src_pos(k)] = st_bits[k];
    end

    assign pending = en_q[GIE_BIT] && (|st_bits);

    evt_irq_out #(.MODE(MODE)) out_i (
        .clk(clk), .rst_n(rst_n), .pending(pending), .irq(irq_out)
    );

    // Read multiplexer; unmapped addresses read zero.
    always_comb begin
        reg_rdata = '0;
        if (sel_en)       reg_rdata = en_q;
        else if (sel_vec) reg_rdata = DATA_W'(vec_q);
        else if (sel_st)  reg_rdata = status_w;
        else if (sel_cap) reg_rdata = CAPS;
    end
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
// Checker for evt_irq_ctrl, attached by bind; observes ports and registers.
module evt_irq_ctrl_chk
    import evt_irq_pkg::*;
#(
    parameter irq_mode_e MODE = IRQ_LVL_HI,
    parameter int unsigned VEC_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic               sel_en,
    input logic               sel_vec,
    input logic               sel_st,
    input logic               sel_cap,
    input logic [NUM_SRC-1:0] evt_in,
    input logic [DATA_W-1:0]  en_q,
    input logic [VEC_W-1:0]   vec_q,
    input logic [DATA_W-1:0]  status_w,
    input logic               irq_out
);
    // R5: enabled data-available event latches.
    a_r5_latch_data: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_in[0] && en_q[0]) |=> status_w[0]);

    // R5 / R7: enabled command-ready event latches, even against a clear.
    a_r7_set_wins_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_in[3] && en_q[7]) |=> status_w[7]);

    // R6: clearing write without a competing event empties the bit.
    a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && sel_st && reg_wdata[1] && !(evt_in[1] && en_q[1])) |=> !status_w[1]);

    // R2: writes outside the map leave enable and vector unchanged.
    a_r2_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !(sel_en || sel_vec || sel_st || sel_cap)) |=> ($stable(en_q) && $stable(vec_q)));

    if (MODE == IRQ_LVL_HI) begin : g_lvl
        // R9: output gated by global enable.
        a_r9_gate: assert property (@(posedge clk) disable iff (!rst_n)
            !en_q[GIE_BIT] |=> !irq_out);
        // R9: pending condition raises the output a cycle later.
        a_r9_raise: assert property (@(posedge clk) disable iff (!rst_n)
            (en_q[GIE_BIT] && (status_w != '0)) |=> irq_out);
    end else if (MODE == IRQ_EDGE_RISE) begin : g_edge
        // R10: pulses last exactly one cycle.
        a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            irq_out |=> !irq_out);
    end
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(.MODE(MODE), .VEC_W(VEC_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .sel_en(sel_en), .sel_vec(sel_vec), .sel_st(sel_st), .sel_cap(sel_cap),
    .evt_in(evt_in), .en_q(en_q), .vec_q(vec_q), .status_w(status_w),
    .irq_out(irq_out)
);

// File: tb/evt_irq_ctrl_tb_top.sv
// Bench: level-high instance dut_i and rising-edge instance dut_e share stimulus.
module evt_irq_ctrl_tb_top;
    import evt_irq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  evt_in = '0;
    logic [31:0] rdata_i, rdata_e;
    logic        irq_i, irq_e;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    evt_irq_ctrl #(.BURST_STATIC(1'b1), .MODE(IRQ_LVL_HI)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_i), .evt_in(evt_in), .irq_out(irq_i)
    );

    evt_irq_ctrl #(.BURST_STATIC(1'b0), .MODE(IRQ_EDGE_RISE)) dut_e (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_e), .evt_in(evt_in), .irq_out(irq_e)
    );

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [31:0] data;
        logic [7:0]  req;
    } vec_t;

    // Register map vectors: writes, then expected read-back.
    localparam vec_t TBL [0:15] = '{
        '{1'b1, 16'h0008, 32'hFFFF_FFFF, 8'd3},  // R3
        '{1'b0, 16'h0008, 32'h8000_0087, 8'd3},
        '{1'b1, 16'h000C, 32'h1234_56AB, 8'd4},  // R4
        '{1'b0, 16'h000C, 32'h0000_00AB, 8'd4},
        '{1'b0, 16'h100C, 32'h0000_00AB, 8'd2},  // R2 page alias
        '{1'b1, 16'h4008, 32'h0000_0001, 8'd2},
        '{1'b0, 16'h0008, 32'h0000_0001, 8'd2},
        '{1'b1, 16'h5008, 32'hFFFF_FFFF, 8'd2},  // R2 page out of range
        '{1'b0, 16'h0008, 32'h0000_0001, 8'd2},
        '{1'b0, 16'h5008, 32'h0000_0000, 8'd2},
        '{1'b1, 16'h0020, 32'hFFFF_FFFF, 8'd2},  // R2 unmapped offset
        '{1'b0, 16'h0020, 32'h0000_0000, 8'd2},
        '{1'b1, 16'h0014, 32'h0000_0000, 8'd8},  // R8 read-only
        '{1'b0, 16'h0014, 32'h0000_018F, 8'd8},
        '{1'b1, 16'h300C, 32'h0000_005A, 8'd4},
        '{1'b0, 16'h000C, 32'h0000_005A, 8'd4}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d, output logic [31:0] de);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = rdata_i; de = rdata_e;
    endtask

    task automatic pulse(input logic [3:0] v);
        @(negedge clk);
        evt_in = v;
        @(negedge clk);
        evt_in = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d, de;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state.
        rd(16'h0008, d, de); check("R1 enable", d, 32'h0);
        rd(16'h000C, d, de); check("R1 vector", d, 32'h0);
        rd(16'h0010, d, de); check("R1 status", d, 32'h0);
        check("R1 irq level", {31'd0, irq_i}, 32'h0);
        check("R1 irq edge", {31'd0, irq_e}, 32'h0);
        // R8 capability for both builds.
        rd(16'h0014, d, de);
        check("R8 caps level-high burst", d, 32'h0000_018F);
        check("R8 caps rising edge", de, 32'h0000_00A7);

        // Register map walk (R2 R3 R4 R8).
        for (int i = 0; i < 16; i++) begin
            if (TBL[i].wr) wr(TBL[i].addr, TBL[i].data);
            else begin
                rd(TBL[i].addr, d, de);
                check($sformatf("R%0d table %0d", TBL[i].req, i), d, TBL[i].data);
            end
        end

        // R5: only enabled source latches, global enable off.
        pulse(4'hF);
        rd(16'h0010, d, de); check("R5 only enabled source", d, 32'h0000_0001);
        @(negedge clk);
        check("R9 no irq without global enable", {31'd0, irq_i}, 32'h0);
        check("R10 no pulse without global enable", {31'd0, irq_e}, 32'h0);

        // Global enable on with status pending: R9 level and R10 pulse.
        wr(16'h0008, 32'h8000_0087);
        check("R10 pulse on enable", {31'd0, irq_e}, 32'h1);
        @(negedge clk);
        check("R10 pulse one cycle", {31'd0, irq_e}, 32'h0);
        check("R9 level raised", {31'd0, irq_i}, 32'h1);

        // R5 source 3 maps to bit 7; R10 no pulse while pending holds.
        pulse(4'b1000);
        check("R10 no repeat pulse", {31'd0, irq_e}, 32'h0);
        rd(16'h0010, d, de); check("R5 command ready at bit 7", d, 32'h0000_0081);

        // R6 write-one-to-clear.
        wr(16'h0010, 32'h0000_0001);
        rd(16'h0010, d, de); check("R6 clear bit 0", d, 32'h0000_0080);
        wr(16'h0010, 32'h0000_0000);
        rd(16'h0010, d, de); check("R6 zero write keeps", d, 32'h0000_0080);
        wr(16'h0010, 32'h0000_0080);
        rd(16'h0010, d, de); check("R6 clear bit 7", d, 32'h0);
        @(negedge clk);
        check("R9 level drops", {31'd0, irq_i}, 32'h0);

        // R7: event meets clearing write in the same cycle.
        pulse(4'b0010);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 16'h0010; reg_wdata = 32'h2; evt_in = 4'b0010;
        @(negedge clk);
        reg_wr = 1'b0; evt_in = '0;
        rd(16'h0010, d, de); check("R7 set wins over clear", d, 32'h0000_0002);
        wr(16'h0010, 32'h0000_0002);
        rd(16'h0010, d, de); check("R6 clear bit 1", d, 32'h0);
        repeat (2) @(negedge clk);

        // R10 fresh pulse from empty status; R9 level follows.
        pulse(4'b0100);
        check("R10 pulse on new event", {31'd0, irq_e}, 32'h1);
        @(negedge clk);
        check("R10 pulse ends", {31'd0, irq_e}, 32'h0);
        check("R9 level on event", {31'd0, irq_i}, 32'h1);

        // R9: dropping the global enable masks a still-pending status.
        wr(16'h0008, 32'h0000_0087);
        @(negedge clk);
        check("R9 masked by global enable", {31'd0, irq_i}, 32'h0);
        rd(16'h0010, d, de); check("R5 status kept while masked", d, 32'h0000_0004);

        finish_run();
    end
endmodule